// File: doc/BRIEF.md
# Control-Transfer Alignment Trap Unit

This unit sits in the execute stage of a small RISC-V style core and judges every control transfer before the fetch unit follows it. Each cycle it may be handed one resolved instruction. The instruction carries its kind, the taken flag of a conditional branch, its own PC, the computed target, the link destination index and the current compressed-instruction enable. From these it selects the next fetch address and decides whether the link register is written. It also decides whether the transfer must instead raise an instruction-address-misaligned trap.

The legal target alignment depends on the compressed-instruction enable. With compressed instructions on, targets on a 2-byte boundary are accepted. With them off, only 4-byte boundaries are accepted. A register-indirect jump drops bit 0 of its target before any check. A transfer that traps leaves the link register and the next fetch address untouched. It reports the address of the offending instruction, the faulting target and the misaligned-fetch cause code. All results are registered and appear one clock after the instruction is presented.

Top module: `xfer_align_trap`

## Requirements
- R1: For a register-indirect jump (in_kind = 2'b10), bit 0 of in_target is cleared before use, so a target whose low two bits are 01 never traps and next_pc becomes in_target with bit 0 cleared.
- R2: With c_en = 0, a direct jump (in_kind = 2'b01), a register-indirect jump, or a taken branch (in_kind = 2'b11, in_taken = 1) whose final target has bit 1 set raises trap_req.
- R3: With c_en = 1, a final target with bit 1 set and bit 0 clear is legal: no trap, and next_pc becomes that target.
- R4: A branch with in_taken = 0 never traps, whatever its target, and next_pc becomes in_pc + 4.
- R5: A trapping transfer never asserts lr_we, even with a nonzero destination.
- R6: On a trap, trap_epc equals the in_pc of the offending instruction.
- R7: On a trap, trap_tval equals the final target (bit 0 cleared for a register-indirect jump).
- R8: On a trap, trap_cause (4 bits) equals 0, the misaligned-fetch code.
- R9: trap_req is a one-cycle pulse per offending instruction, and on a trap next_pc keeps its previous value.
- R10: A non-trapping direct or register-indirect jump asserts lr_we with lr_rd = in_rd and lr_wdata = in_pc + 4. The write is suppressed when in_rd = 0.
- R11: Results appear one cycle after in_valid is sampled, flagged by out_valid. A sequential instruction (in_kind = 2'b00) sets next_pc to in_pc + 4. After reset, next_pc equals RESET_PC and out_valid, lr_we and trap_req are 0.
- R12: A final target of a direct jump or taken branch with bit 0 set traps in either c_en mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_kind | input | 2 | 00 sequential, 01 direct jump, 10 register-indirect jump, 11 branch |
| in_taken | input | 1 | Branch outcome, used for kind 11 only |
| in_pc | input | 32 | Address of the presented instruction |
| in_target | input | 32 | Computed transfer target |
| in_rd | input | 5 | Link destination register index |
| c_en | input | 1 | Compressed instructions enabled |
| out_valid | output | 1 | Registered results refer to an instruction |
| next_pc | output | 32 | Next fetch address |
| lr_we | output | 1 | Link register write enable |
| lr_rd | output | 5 | Link register index |
| lr_wdata | output | 32 | Link value |
| trap_req | output | 1 | Misaligned-fetch trap pulse |
| trap_cause | output | 4 | Trap cause code |
| trap_epc | output | 32 | Address of the trapping instruction |
| trap_tval | output | 32 | Faulting target address |

## Verification
The assertions check every cycle that a trap never comes with a link write and that next_pc holds through a trap. They also check the cause code, that the reported PC tracks the offending instruction, and that the alignment rules for each c_en setting and for untaken branches are followed. Only the bench scenarios show exact values. These are the exact next_pc and link value for each instruction kind, the reported faulting target, the suppression of writes to register 0, the pulse ending after one cycle with back-to-back instructions, and the reset state both at start-up and mid-run.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    XK_SEQ  = 2'b00,
    XK_JAL  = 2'b01,
    XK_JALR = 2'b10,
    XK_BR   = 2'b11
  } xfer_kind_e;

  localparam int unsigned CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_FETCH_MISALIGN = '0;

endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xfer_target_calc.sv
module xfer_target_calc
  import xfer_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned INSN_B = 4
) (
  input  xfer_kind_e      kind,
  input  logic            taken,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] final_tgt,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] cand_pc,
  output logic            redirect
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

  always_comb begin
    seq_pc    = pc + STEP;
    final_tgt = target;
    if (kind == XK_JALR) final_tgt[0] = 1'b0;
    unique case (kind)
      XK_JAL, XK_JALR: redirect = 1'b1;
      XK_BR:           redirect = taken;
      default:         redirect = 1'b0;
    endcase
    cand_pc = redirect ? final_tgt : seq_pc;
  end
endmodule

// File: rtl/xfer_align_chk.sv
module xfer_align_chk #(
  parameter int unsigned XLEN = 32
) (
  input  logic            redirect,
  input  logic [XLEN-1:0] final_tgt,
  input  logic            c_en,
  output logic            misaligned
);
  logic odd_byte;
  logic half_word;

  always_comb begin
    odd_byte   = final_tgt[0];
    half_word  = final_tgt[1] & ~c_en;
    misaligned = redirect & (odd_byte | half_word);
  end
endmodule

// File: rtl/xfer_link_ctl.sv
module xfer_link_ctl
  import xfer_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned REG_AW = 5
) (
  input  xfer_kind_e        kind,
  input  logic [REG_AW-1:0] rd,
  input  logic              misaligned,
  input  logic [XLEN-1:0]   seq_pc,
  output logic              wr_en,
  output logic [XLEN-1:0]   wr_data
);
  logic is_jump;

  always_comb begin
    is_jump = (kind == XK_JAL) || (kind == XK_JALR);
    wr_en   = is_jump && !misaligned && (rd != '0);
    wr_data = seq_pc;
  end
endmodule

// File: rtl/xfer_align_trap.sv
module xfer_align_trap
  import xfer_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned INSN_B   = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         in_kind,
  input  logic               in_taken,
  input  logic [XLEN-1:0]    in_pc,
  input  logic [XLEN-1:0]    in_target,
  input  logic [REG_AW-1:0]  in_rd,
  input  logic               c_en,
  output logic               out_valid,
  output logic [XLEN-1:0]    next_pc,
  output logic               lr_we,
  output logic [REG_AW-1:0]  lr_rd,
  output logic [XLEN-1:0]    lr_wdata,
  output logic               trap_req,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic [XLEN-1:0]    trap_epc,
  output logic [XLEN-1:0]    trap_tval
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_B);

  logic       rst_q_n;
  xfer_kind_e kind;
  logic [XLEN-1:0] final_tgt, seq_pc, cand_pc, link_data;
  logic redirect, misaligned, link_en;

  assign kind = xfer_kind_e'(in_kind);

  xfer_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_q_n)
  );

  xfer_target_calc #(.XLEN(XLEN), .INSN_B(INSN_B)) u_tgt (
    .kind      (kind),
    .taken     (in_taken),
    .pc        (in_pc),
    .target    (in_target),
    .final_tgt (final_tgt),
    .seq_pc    (seq_pc),
    .cand_pc   (cand_pc),
    .redirect  (redirect)
  );

  xfer_align_chk #(.XLEN(XLEN)) u_chk (
    .redirect   (redirect),
    .final_tgt  (final_tgt),
    .c_en       (c_en),
    .misaligned (misaligned)
  );

  xfer_link_ctl #(.XLEN(XLEN), .REG_AW(REG_AW)) u_link (
    .kind       (kind),
    .rd         (in_rd),
    .misaligned (misaligned),
    .seq_pc     (seq_pc),
    .wr_en      (link_en),
    .wr_data    (link_data)
  );

  // next-state
  logic pc_ce, trap_ce, lk_ce;
  logic               out_valid_d, lr_we_d, trap_req_d;
  logic [XLEN-1:0]    next_pc_d, lr_wdata_d, trap_epc_d, trap_tval_d;
  logic [REG_AW-1:0]  lr_rd_d;
  logic [CAUSE_W-1:0] trap_cause_d;

  always_comb begin
    pc_ce        = in_valid && !misaligned;
    trap_ce      = in_valid && misaligned;
    lk_ce        = in_valid;
    out_valid_d  = in_valid;
    trap_req_d   = trap_ce;
    lr_we_d      = in_valid && link_en;
    next_pc_d    = pc_ce ? cand_pc : next_pc;
    lr_rd_d      = lk_ce ? in_rd : lr_rd;
    lr_wdata_d   = lk_ce ? link_data : lr_wdata;
    trap_epc_d   = trap_ce ? in_pc : trap_epc;
    trap_tval_d  = trap_ce ? final_tgt : trap_tval;
    trap_cause_d = trap_ce ? CAUSE_FETCH_MISALIGN : trap_cause;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid  <= 1'b0;
      trap_req   <= 1'b0;
      lr_we      <= 1'b0;
      next_pc    <= RESET_PC[XLEN-1:0];
      lr_rd      <= '0;
      lr_wdata   <= '0;
      trap_epc   <= '0;
      trap_tval  <= '0;
      trap_cause <= '0;
    end else begin
      out_valid  <= out_valid_d;
      trap_req   <= trap_req_d;
      lr_we      <= lr_we_d;
      next_pc    <= next_pc_d;
      lr_rd      <= lr_rd_d;
      lr_wdata   <= lr_wdata_d;
      trap_epc   <= trap_epc_d;
      trap_tval  <= trap_tval_d;
      trap_cause <= trap_cause_d;
    end
  end

  // checks on the registered results
  assert_jalr_low_bit_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_kind == 2'b10 && in_target[1:0] == 2'b01) |=> !trap_req);

  assert_half_align_trap_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && !c_en && in_target[1] &&
     (in_kind == 2'b01 || in_kind == 2'b10 || (in_kind == 2'b11 && in_taken))) |=> trap_req);

  assert_compressed_legal_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && c_en && in_kind == 2'b10) |=> !trap_req);

  assert_untaken_seq_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_kind == 2'b11 && !in_taken) |=>
      (!trap_req && next_pc == $past(in_pc) + STEP));

  assert_no_link_on_trap_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_req |-> !lr_we);

  assert_epc_is_insn_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && misaligned) |=> (trap_epc == $past(in_pc)));

  assert_cause_code_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_req |-> (trap_cause == CAUSE_FETCH_MISALIGN));

  assert_pc_hold_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    trap_req |-> $stable(next_pc));

  assert_out_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    (trap_req || lr_we) |-> out_valid);

endmodule

// File: tb/sim_xfer_align_trap.sv
`timescale 1ns/1ps
module sim_xfer_align_trap;
  localparam logic [31:0] RPC = 32'h0000_1000;
  localparam int NV = 13;

  // kind: 0 seq, 1 jal, 2 jalr, 3 branch
  localparam logic [1:0]  T_KIND  [NV] = '{2'd1, 2'd1, 2'd2, 2'd2, 2'd2, 2'd3, 2'd3,
                                           2'd3, 2'd1, 2'd0, 2'd1, 2'd3, 2'd2};
  localparam logic        T_TAKEN [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0,
                                           1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic        T_CEN   [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0,
                                           1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [31:0] T_PC    [NV] = '{32'h100, 32'h104, 32'h120, 32'h124, 32'h128,
                                           32'h130, 32'h140, 32'h144, 32'h148, 32'h150,
                                           32'h160, 32'h164, 32'h168};
  localparam logic [31:0] T_TGT   [NV] = '{32'h200, 32'h302, 32'h401, 32'h403, 32'h403,
                                           32'h506, 32'h506, 32'h506, 32'h600, 32'h0,
                                           32'h701, 32'h801, 32'h90A};
  localparam logic [4:0]  T_RD    [NV] = '{5'd1, 5'd1, 5'd2, 5'd3, 5'd4, 5'd0, 5'd0,
                                           5'd0, 5'd0, 5'd0, 5'd5, 5'd0, 5'd0};
  localparam logic        T_TRAP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                           1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam string       T_REQ   [NV] = '{"R10", "R2", "R1", "R7", "R3", "R2", "R4",
                                           "R3", "R10", "R11", "R12", "R12", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_kind = 2'd0;
  logic in_taken = 1'b0;
  logic [31:0] in_pc = '0, in_target = '0;
  logic [4:0] in_rd = '0;
  logic c_en = 1'b0;
  logic out_valid, lr_we, trap_req;
  logic [31:0] next_pc, lr_wdata, trap_epc, trap_tval;
  logic [4:0] lr_rd;
  logic [3:0] trap_cause;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xfer_align_trap #(.RESET_PC(RPC)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_taken(in_taken), .in_pc(in_pc), .in_target(in_target), .in_rd(in_rd),
    .c_en(c_en), .out_valid(out_valid), .next_pc(next_pc), .lr_we(lr_we),
    .lr_rd(lr_rd), .lr_wdata(lr_wdata), .trap_req(trap_req),
    .trap_cause(trap_cause), .trap_epc(trap_epc), .trap_tval(trap_tval)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic tk, input logic ce,
                       input logic [31:0] pc, input logic [31:0] tg, input logic [4:0] rd);
    in_valid = 1'b1; in_kind = k; in_taken = tk; c_en = ce;
    in_pc = pc; in_target = tg; in_rd = rd;
  endtask

  logic [31:0] exp_npc;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11", "reset next_pc", next_pc, RPC);
    chk("R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R11", "reset trap_req", {31'd0, trap_req}, 32'd0);
    chk("R11", "reset lr_we", {31'd0, lr_we}, 32'd0);
    exp_npc = RPC;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] ftgt;
      logic redir, mis, we;
      drive(T_KIND[i], T_TAKEN[i], T_CEN[i], T_PC[i], T_TGT[i], T_RD[i]);
      ftgt  = (T_KIND[i] == 2'd2) ? (T_TGT[i] & ~32'd1) : T_TGT[i];
      redir = (T_KIND[i] == 2'd1) || (T_KIND[i] == 2'd2) || (T_KIND[i] == 2'd3 && T_TAKEN[i]);
      mis   = redir && (ftgt[0] || (!T_CEN[i] && ftgt[1]));
      we    = (T_KIND[i] == 2'd1 || T_KIND[i] == 2'd2) && !mis && (T_RD[i] != 5'd0);
      if (!mis) exp_npc = redir ? ftgt : T_PC[i] + 32'd4;
      @(negedge clk);
      in_valid = 1'b0;
      chk("R11", "out_valid", {31'd0, out_valid}, 32'd1);
      chk(T_REQ[i], "trap_req", {31'd0, trap_req}, {31'd0, T_TRAP[i]});
      chk(T_REQ[i], "next_pc", next_pc, exp_npc);
      chk(T_REQ[i], "lr_we", {31'd0, lr_we}, {31'd0, we});
      if (we) begin
        chk("R10", "lr_wdata", lr_wdata, T_PC[i] + 32'd4);
        chk("R10", "lr_rd", {27'd0, lr_rd}, {27'd0, T_RD[i]});
      end
      if (T_TRAP[i]) begin
        chk("R6", "trap_epc", trap_epc, T_PC[i]);
        chk("R7", "trap_tval", trap_tval, ftgt);
        chk("R8", "trap_cause", {28'd0, trap_cause}, 32'd0);
      end
      @(negedge clk);
      chk("R9", "pulse ends", {31'd0, trap_req}, 32'd0);
    end

    // R9 back-to-back: trap then legal jump on consecutive cycles
    drive(2'd1, 1'b0, 1'b0, 32'h200, 32'h20E, 5'd7);
    @(negedge clk);
    chk("R9", "b2b trap", {31'd0, trap_req}, 32'd1);
    chk("R9", "b2b hold pc", next_pc, exp_npc);
    drive(2'd1, 1'b0, 1'b0, 32'h204, 32'h300, 5'd7);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "b2b pulse one cycle", {31'd0, trap_req}, 32'd0);
    chk("R10", "b2b jump pc", next_pc, 32'h300);
    chk("R10", "b2b link data", lr_wdata, 32'h208);
    chk("R5", "b2b link after trap", {31'd0, lr_we}, 32'd1);

    // R11 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "mid reset next_pc", next_pc, RPC);
    chk("R11", "mid reset out_valid", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11", "post reset idle", {31'd0, lr_we | trap_req}, 32'd0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule